// File: doc/BRIEF.md
# Narrowing Clip Shifter

This block takes one source element of twice the target width and narrows it to a target element width of 8, 16 or 32 bits. The source is shifted right by an amount taken from a shift operand. The shift is logical for unsigned data and arithmetic for signed data. The bits shifted out are rounded under one of four rounding modes. The rounded value is then clamped to the range of the target width, and a saturation flag reports any clamp.

Each request is presented for one cycle with `inValid` high. The result, the saturation flag and the illegal-width flag appear together with `outValid` one clock later. A target width select of 64 bits is outside what the block supports. Such a request produces a zero result with the illegal flag set. Register grouping, element indexing and masking belong to the surrounding vector logic.

Top module: `nclip_unit`

## Requirements
- R1: After reset, `outValid`, `result`, `sat` and `illegal` are all zero.
- R2: A request sampled with `inValid` high appears on the outputs after the next rising edge, with `outValid` high for that one cycle. While `inValid` is low, `outValid` is low and `result`, `sat` and `illegal` keep their values.
- R3: The effective shift amount is `shiftOp` ANDed with (2*SEW - 1). That is 4 bits for SEW 8, 5 bits for SEW 16 and 6 bits for SEW 32.
- R4: With `signedMode` = 0, the source is taken as the low 2*SEW bits of `srcWide`, zero-extended, and shifted logically. Higher bits of `srcWide` have no effect.
- R5: With `signedMode` = 1, the low 2*SEW bits are sign-extended from bit 2*SEW-1 and shifted arithmetically.
- R6: `roundMode` = 0 (round to nearest, ties up) adds the guard bit. The guard bit is the bit at position shift-1 of the source.
- R7: `roundMode` = 1 (round to nearest, ties even) adds the guard bit only when the sticky bit or the kept LSB is 1. The sticky bit is the OR of all source bits below the guard, and it is used only for shifts of 2 or more.
- R8: `roundMode` = 2 truncates and adds nothing.
- R9: `roundMode` = 3 (round to odd) adds 1 when the kept LSB is 0 and either the guard bit or the sticky bit is 1.
- R10: A zero effective shift adds no rounding increment, in every mode.
- R11: Unsigned: if the rounded value is above 2^SEW-1, the result is all ones at SEW and `sat` is 1. At exactly 2^SEW-1, `sat` is 0.
- R12: Signed: a rounded value above the signed SEW maximum gives the maximum, and one below the minimum gives the minimum. `sat` is 1 in both cases and 0 at the exact bounds.
- R13: `widthSel` encodes 0 = SEW 8, 1 = SEW 16, 2 = SEW 32. The value 3 (SEW 64) is illegal and gives `result` = 0, `sat` = 0 and `illegal` = 1. Legal selects give `illegal` = 0.
- R14: For SEW below 32, the narrowed value is zero-extended into the 32-bit `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| srcWide | input | 64 | Wide source element, low 2*SEW bits used |
| shiftOp | input | 32 | Raw shift operand |
| widthSel | input | 2 | Target width select |
| signedMode | input | 1 | 1 = signed clip, 0 = unsigned clip |
| roundMode | input | 2 | Rounding mode |
| outValid | output | 1 | Result strobe |
| result | output | 32 | Narrowed element, zero-extended |
| sat | output | 1 | Clamp occurred |
| illegal | output | 1 | Width select not supported |

## Verification
The bench uses the package defaults: a base width of 8 and three lanes. This gives target widths of 8, 16 and 32 with shift masks of 4, 5 and 6 bits. A shift operand of all ones therefore masks to the largest legal shift in every lane. The 64-bit source reaches the full-width signed bounds at SEW 32. The directed cases place the guard and sticky bits so that each rounding mode gives a different answer, including negative values rounding up to zero. They also cover a round-up that carries past the unsigned maximum.

// File: rtl/nclip_pkg.sv
package nclip_pkg;
  localparam int BASE_SEW  = 8;
  localparam int NUM_LANES = 3;
  localparam int MAX_SEW   = BASE_SEW << (NUM_LANES - 1);
  localparam int WIDE_W    = 2 * MAX_SEW;
  localparam int SEL_W     = $clog2(NUM_LANES + 1);

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ODD       = 2'd3
  } roundMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 capture;
    logic                 illegal;
    logic [NUM_LANES-1:0] laneSel;
  } ctlStrobes_t;
endpackage

// File: rtl/nclip_ctrl.sv
module nclip_ctrl
  import nclip_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEL_W-1:0] widthSel,
  output ctlStrobes_t      strobes,
  output logic             outValid
);
  logic [NUM_LANES-1:0] laneSel;
  logic                 badWidth;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_sel
    assign laneSel[k] = (widthSel == SEL_W'(k));
  end

  assign badWidth = (widthSel >= SEL_W'(NUM_LANES));

  always_comb begin
    strobes.capture = inValid;
    strobes.illegal = badWidth;
    strobes.laneSel = laneSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_lane_onehot_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneSel) && (!badWidth || laneSel == '0));
endmodule

// File: rtl/nclip_lane.sv
module nclip_lane
  import nclip_pkg::*;
#(
  parameter int SEW = 8,
  localparam int W   = 2 * SEW,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src,
  input  logic [SHW-1:0] shamt,
  input  logic           signedMode,
  input  roundMode_e     roundMode,
  output logic [SEW-1:0] res,
  output logic           sat
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] U_MAX = {{(XW-SEW){1'b0}}, {SEW{1'b1}}};
  localparam logic signed [XW-1:0] S_MAX = {{(XW-SEW+1){1'b0}}, {(SEW-1){1'b1}}};
  localparam logic signed [XW-1:0] S_MIN = {{(XW-SEW+1){1'b1}}, {(SEW-1){1'b0}}};

  logic signed [XW-1:0] extSrc, shifted, rounded;
  logic [W-1:0]         stickyMask;
  logic                 guardBit, stickyBit, keptLsb, inc;

  assign extSrc  = {{2{signedMode & src[W-1]}}, src};
  assign shifted = extSrc >>> shamt;
  assign keptLsb = shifted[0];

  always_comb begin
    guardBit = 1'b0;
    if (shamt != '0) guardBit = src[shamt - SHW'(1)];
  end

  always_comb begin
    stickyMask = '0;
    if (shamt >= SHW'(2)) stickyMask = (W'(1) << (shamt - SHW'(1))) - W'(1);
  end

  assign stickyBit = |(src & stickyMask);

  always_comb begin
    unique case (roundMode)
      RND_NEAR_UP:   inc = guardBit;
      RND_NEAR_EVEN: inc = guardBit & (stickyBit | keptLsb);
      RND_DOWN:      inc = 1'b0;
      RND_ODD:       inc = ~keptLsb & (guardBit | stickyBit);
      default:       inc = 1'b0;
    endcase
  end

  assign rounded = shifted + $signed({{(XW-1){1'b0}}, inc});

  always_comb begin
    sat = 1'b0;
    res = rounded[SEW-1:0];
    if (signedMode) begin
      if (rounded > S_MAX) begin
        sat = 1'b1;
        res = S_MAX[SEW-1:0];
      end else if (rounded < S_MIN) begin
        sat = 1'b1;
        res = S_MIN[SEW-1:0];
      end
    end else if (rounded > U_MAX) begin
      sat = 1'b1;
      res = {SEW{1'b1}};
    end
  end
endmodule

// File: rtl/nclip_datapath.sv
module nclip_datapath
  import nclip_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [WIDE_W-1:0]  srcWide,
  input  logic [MAX_SEW-1:0] shiftOp,
  input  logic               signedMode,
  input  roundMode_e         roundMode,
  output logic [MAX_SEW-1:0] result,
  output logic               sat,
  output logic               illegal
);
  logic [MAX_SEW-1:0]   laneRes [NUM_LANES];
  logic [NUM_LANES-1:0] laneSat;
  logic [MAX_SEW-1:0]   nextRes;
  logic                 nextSat;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int LS  = BASE_SEW << k;
    localparam int LSH = $clog2(2 * LS);
    logic [LS-1:0] res;
    nclip_lane #(.SEW(LS)) lane_i (
      .src       (srcWide[2*LS-1:0]),
      .shamt     (shiftOp[LSH-1:0]),
      .signedMode(signedMode),
      .roundMode (roundMode),
      .res       (res),
      .sat       (laneSat[k])
    );
    assign laneRes[k] = MAX_SEW'(res);
  end

  always_comb begin
    nextRes = '0;
    nextSat = 1'b0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (strobes.laneSel[k] && !strobes.illegal) begin
        nextRes = nextRes | laneRes[k];
        nextSat = nextSat | laneSat[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      sat     <= 1'b0;
      illegal <= 1'b0;
    end else if (strobes.capture) begin
      result  <= nextRes;
      sat     <= nextSat;
      illegal <= strobes.illegal;
    end
  end

  p_illegal_clean_r13: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0 && !sat));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(result) && $stable(sat) && $stable(illegal)));
  p_zero_ext_r14: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.laneSel[0]) |=> (result[MAX_SEW-1:BASE_SEW] == '0));
  p_unsigned_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !signedMode && nextSat && strobes.laneSel[0])
      |=> (result == MAX_SEW'({BASE_SEW{1'b1}})));
endmodule

// File: rtl/nclip_unit.sv
module nclip_unit
  import nclip_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDE_W-1:0]  srcWide,
  input  logic [MAX_SEW-1:0] shiftOp,
  input  logic [SEL_W-1:0]   widthSel,
  input  logic               signedMode,
  input  logic [1:0]         roundMode,
  output logic               outValid,
  output logic [MAX_SEW-1:0] result,
  output logic               sat,
  output logic               illegal
);
  ctlStrobes_t strobes;

  nclip_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .widthSel(widthSel),
    .strobes (strobes),
    .outValid(outValid)
  );

  nclip_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcWide   (srcWide),
    .shiftOp   (shiftOp),
    .signedMode(signedMode),
    .roundMode (roundMode_e'(roundMode)),
    .result    (result),
    .sat       (sat),
    .illegal   (illegal)
  );
endmodule

// File: tb/nclip_unit_tb_top.sv
module nclip_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcWide = '0;
  logic [31:0] shiftOp = '0;
  logic [1:0]  widthSel = '0;
  logic        signedMode = 1'b0;
  logic [1:0]  roundMode = '0;
  logic        outValid, sat, illegal;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nclip_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWide(srcWide),
    .shiftOp(shiftOp), .widthSel(widthSel), .signedMode(signedMode),
    .roundMode(roundMode), .outValid(outValid), .result(result),
    .sat(sat), .illegal(illegal)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runCase(string tag, logic [1:0] sel, logic sgn, logic [1:0] mode,
                         logic [63:0] src, logic [31:0] op,
                         logic [31:0] expRes, logic expSat, logic expIll);
    @(negedge clk);
    inValid = 1'b1; widthSel = sel; signedMode = sgn; roundMode = mode;
    srcWide = src; shiftOp = op;
    @(negedge clk);
    inValid = 1'b0;
    chk(tag, "outValid", 64'(outValid), 64'd1);
    chk(tag, "result", 64'(result), 64'(expRes));
    chk(tag, "sat", 64'(sat), 64'(expSat));
    chk(tag, "illegal", 64'(illegal), 64'(expIll));
  endtask

  task automatic testReset();
    chk("R1", "outValid", 64'(outValid), 64'd0);
    chk("R1", "result", 64'(result), 64'd0);
    chk("R1", "sat", 64'(sat), 64'd0);
    chk("R1", "illegal", 64'(illegal), 64'd0);
  endtask

  task automatic testMaskAndExtend();
    // R3 R4: SEW8, op 0x14 -> shift 4, upper source bits ignored
    runCase("R3", 2'd0, 1'b0, 2'd2, 64'hDEAD_BEEF_0000_0AB0, 32'h14, 32'hAB, 1'b0, 1'b0);
    // R3: SEW32, op all ones -> shift 63, guard bit 62 rounds up
    runCase("R3", 2'd2, 1'b0, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
    // R5 R14: signed SEW8 -128 >> 2 = -32 -> 0xE0 zero-extended
    runCase("R5", 2'd0, 1'b1, 2'd2, 64'h0000_0000_0000_FF80, 32'd2, 32'hE0, 1'b0, 1'b0);
    // R5: signed SEW16 with junk above bit 31
    runCase("R5", 2'd1, 1'b1, 2'd2, 64'h1234_5678_FFFF_FFF8, 32'd4, 32'hFFFF, 1'b0, 1'b0);
  endtask

  task automatic testRounding();
    // 0x128 >> 4: kept 0x12, guard 1, sticky 0
    runCase("R6", 2'd1, 1'b0, 2'd0, 64'h128, 32'd4, 32'h13, 1'b0, 1'b0);
    runCase("R7", 2'd1, 1'b0, 2'd1, 64'h128, 32'd4, 32'h12, 1'b0, 1'b0);
    runCase("R8", 2'd1, 1'b0, 2'd2, 64'h128, 32'd4, 32'h12, 1'b0, 1'b0);
    runCase("R9", 2'd1, 1'b0, 2'd3, 64'h128, 32'd4, 32'h13, 1'b0, 1'b0);
    // 0x138: kept odd, tie
    runCase("R7", 2'd1, 1'b0, 2'd1, 64'h138, 32'd4, 32'h14, 1'b0, 1'b0);
    runCase("R9", 2'd1, 1'b0, 2'd3, 64'h138, 32'd4, 32'h13, 1'b0, 1'b0);
    // 0x129: guard and sticky
    runCase("R7", 2'd1, 1'b0, 2'd1, 64'h129, 32'd4, 32'h13, 1'b0, 1'b0);
    // 0x124: sticky only
    runCase("R6", 2'd1, 1'b0, 2'd0, 64'h124, 32'd4, 32'h12, 1'b0, 1'b0);
    runCase("R9", 2'd1, 1'b0, 2'd3, 64'h124, 32'd4, 32'h13, 1'b0, 1'b0);
    // signed -8 >> 4 = -1, guard 1
    runCase("R6", 2'd1, 1'b1, 2'd0, 64'hFFFF_FFF8, 32'd4, 32'h0, 1'b0, 1'b0);
    runCase("R7", 2'd1, 1'b1, 2'd1, 64'hFFFF_FFF8, 32'd4, 32'h0, 1'b0, 1'b0);
    runCase("R9", 2'd1, 1'b1, 2'd3, 64'hFFFF_FFF8, 32'd4, 32'hFFFF, 1'b0, 1'b0);
    // R10: op 32 masks to 0 at SEW16
    runCase("R10", 2'd1, 1'b0, 2'd3, 64'h1234, 32'd32, 32'h1234, 1'b0, 1'b0);
    runCase("R10", 2'd1, 1'b0, 2'd0, 64'h1234, 32'd32, 32'h1234, 1'b0, 1'b0);
  endtask

  task automatic testClip();
    runCase("R11", 2'd2, 1'b0, 2'd2, 64'h0000_0001_0000_0000, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    runCase("R11", 2'd2, 1'b0, 2'd2, 64'h0000_0000_FFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    runCase("R11", 2'd0, 1'b0, 2'd0, 64'h01FF, 32'd1, 32'hFF, 1'b1, 1'b0);
    runCase("R12", 2'd0, 1'b1, 2'd2, 64'h7FFF, 32'd4, 32'h7F, 1'b1, 1'b0);
    runCase("R12", 2'd0, 1'b1, 2'd2, 64'h8000, 32'd4, 32'h80, 1'b1, 1'b0);
    runCase("R12", 2'd2, 1'b1, 2'd2, 64'hFFFF_FFFF_0000_0000, 32'd1, 32'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic testIllegal();
    runCase("R13", 2'd3, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 32'h0, 1'b0, 1'b1);
    runCase("R13", 2'd1, 1'b0, 2'd2, 64'h0000_5000, 32'd8, 32'h50, 1'b0, 1'b0);
  endtask

  task automatic testHold();
    runCase("R2", 2'd0, 1'b0, 2'd2, 64'h0000_0AB0, 32'd4, 32'hAB, 1'b0, 1'b0);
    @(negedge clk);
    srcWide = 64'hFFFF; widthSel = 2'd3; shiftOp = 32'd0;
    @(negedge clk);
    chk("R2", "outValid idle", 64'(outValid), 64'd0);
    chk("R2", "result held", 64'(result), 64'hAB);
    chk("R2", "illegal held", 64'(illegal), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testMaskAndExtend();
    testRounding();
    testClip();
    testIllegal();
    testHold();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule